// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer with Recency Replacement

The block caches recent virtual-to-physical page translations. An incoming virtual address is split into a page number and an untranslated offset. The page number is compared at the same time against the tag of every stored translation. On a match, the stored frame number is joined to the offset to form the physical address. The lookup path is purely combinational, so a requester sees hit, physical address and dirty status in the same cycle it presents the address.

Each entry keeps a small saturating recency counter. A hit or a fill makes the entry most recent, with a count of zero, and ages every other live entry by one until it reaches the maximum. When a miss has been resolved elsewhere, the requester installs the translation through the fill port. The block picks the slot itself: it takes a free slot first, otherwise the oldest slot. A write access that hits marks its page dirty. A global invalidate empties the table in one clock.

Top module: `tlb_fa`

## Requirements
- R1: After synchronous reset every entry is invalid, so every lookup misses until a fill is made.
- R2: `lk_hit` is 1 only when `lk_valid` is 1 and a valid entry's tag equals the page number `lk_vaddr[OFF_W+VPN_W-1:OFF_W]`. The bench never stores one page number twice, so at most one entry matches.
- R3: On a hit, `lk_paddr` is the stored frame number in bits `[OFF_W+PFN_W-1:OFF_W]` and `lk_vaddr[OFF_W-1:0]` in the low bits. On a miss, `lk_paddr` is 0.
- R4: `lk_dirty` gives the stored dirty flag of the matching entry, as it was before this cycle's update. It is 0 on a miss.
- R5: A lookup with `lk_write` = 1 that hits, with no fill or invalidate in the same cycle, sets that entry's dirty flag from the next cycle on.
- R6: A hit that has no fill or invalidate in the same cycle sets that entry's counter to 0 at the clock edge. Each other valid entry whose counter is below its maximum (3 for a 2-bit counter) increases it by 1. Invalid entries keep their counter.
- R7: A fill takes the lowest-numbered invalid entry when one exists.
- R8: With every entry valid, a fill takes the lowest-numbered entry whose counter is at its maximum, or entry 0 if none is.
- R9: A fill stores `fill_vpn`, `fill_pfn` and `fill_dirty` in the chosen entry and marks it valid. It ages the counters exactly as a hit on that entry does.
- R10: `inv_all` clears every valid flag at the next clock edge. In that cycle it overrides any fill or lookup update.
- R11: When `fill_en` and a hitting lookup occur in the same cycle, the fill is performed. That lookup changes neither the counters nor the dirty flags, but its combinational outputs are still reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_write | input | 1 | Lookup is a write access |
| lk_vaddr | input | VPN_W+OFF_W | Virtual address to translate |
| lk_hit | output | 1 | Translation found |
| lk_paddr | output | PFN_W+OFF_W | Translated physical address |
| lk_dirty | output | 1 | Dirty flag of the hit entry |
| fill_en | input | 1 | Install a translation |
| fill_vpn | input | VPN_W | Page number to install |
| fill_pfn | input | PFN_W | Frame number to install |
| fill_dirty | input | 1 | Initial dirty flag for the installed entry |
| inv_all | input | 1 | Invalidate every entry |

## Verification
The bench builds the block with 8 entries. It keeps the default 30-bit page number, 13-bit offset, 21-bit frame and 2-bit counters. With 8 slots and a pool of 16 page numbers, random fills fill the table within a few cycles. Eviction by oldest-then-lowest index then happens constantly, and several entries share the saturated count, so the tie-break order is exercised often. Directed steps set up the free-slot choice, the saturation pattern after a full fill sequence, fill-versus-lookup collisions, and an invalidate that collides with a fill.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int unsigned DEF_ENTRIES = 32;
    localparam int unsigned DEF_VPN_W   = 30;
    localparam int unsigned DEF_OFF_W   = 13;
    localparam int unsigned DEF_PFN_W   = 21;
    localparam int unsigned DEF_AGE_W   = 2;

    // What the table does at the coming clock edge, in priority order
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_TOUCH = 2'd1,
        OP_FILL  = 2'd2,
        OP_FLUSH = 2'd3
    } tlb_op_e;

    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
    parameter int unsigned ENTRIES = tlb_pkg::DEF_ENTRIES,
    parameter int unsigned VPN_W   = tlb_pkg::DEF_VPN_W,
    parameter int unsigned PFN_W   = tlb_pkg::DEF_PFN_W,
    localparam int unsigned IDX_W  = tlb_pkg::idx_width(ENTRIES)
) (
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic [VPN_W-1:0]   tag_arr [ENTRIES],
    input  logic [PFN_W-1:0]   pfn_arr [ENTRIES],
    input  logic [ENTRIES-1:0] dirty_vec,
    input  logic [VPN_W-1:0]   key,
    output logic [ENTRIES-1:0] hit_vec,
    output logic               any_hit,
    output logic [IDX_W-1:0]   hit_idx,
    output logic [PFN_W-1:0]   hit_pfn,
    output logic               hit_dirty
);
    // One comparator per slot, all evaluated at once
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = valid_vec[g] && (tag_arr[g] == key);
    end

    assign any_hit   = |hit_vec;
    assign hit_dirty = |(hit_vec & dirty_vec);

    // AND-OR selection; relies on at most one active match line
    always_comb begin
        hit_pfn = '0;
        hit_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            hit_pfn = hit_pfn | (pfn_arr[i] & {PFN_W{hit_vec[i]}});
            hit_idx = hit_idx | (IDX_W'(i) & {IDX_W{hit_vec[i]}});
        end
    end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int unsigned ENTRIES = tlb_pkg::DEF_ENTRIES,
    parameter int unsigned AGE_W   = tlb_pkg::DEF_AGE_W,
    localparam int unsigned IDX_W  = tlb_pkg::idx_width(ENTRIES)
) (
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic [AGE_W-1:0]   age_arr [ENTRIES],
    output logic [IDX_W-1:0]   victim_idx
);
    localparam logic [AGE_W-1:0] AGE_MAX = '1;

    logic             free_found, old_found;
    logic [IDX_W-1:0] free_idx, old_idx;

    // Scan from the top so the lowest qualifying index is kept last
    always_comb begin
        free_found = 1'b0;
        old_found  = 1'b0;
        free_idx   = '0;
        old_idx    = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
            if (age_arr[i] == AGE_MAX) begin
                old_found = 1'b1;
                old_idx   = IDX_W'(i);
            end
        end
        if (free_found)
            victim_idx = free_idx;
        else if (old_found)
            victim_idx = old_idx;
        else
            victim_idx = '0;
    end
endmodule

// File: rtl/tlb_age.sv
module tlb_age #(
    parameter int unsigned ENTRIES = tlb_pkg::DEF_ENTRIES,
    parameter int unsigned AGE_W   = tlb_pkg::DEF_AGE_W,
    localparam int unsigned IDX_W  = tlb_pkg::idx_width(ENTRIES)
) (
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic [AGE_W-1:0]   age_arr [ENTRIES],
    input  logic [IDX_W-1:0]   sel_idx,
    output logic [AGE_W-1:0]   age_nxt [ENTRIES]
);
    localparam logic [AGE_W-1:0] AGE_MAX = '1;

    // Selected slot becomes youngest; other live slots age with saturation
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cnt
        always_comb begin
            if (sel_idx == IDX_W'(g))
                age_nxt[g] = '0;
            else if (valid_vec[g] && (age_arr[g] != AGE_MAX))
                age_nxt[g] = age_arr[g] + 1'b1;
            else
                age_nxt[g] = age_arr[g];
        end
    end
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa #(
    parameter int unsigned ENTRIES = tlb_pkg::DEF_ENTRIES,
    parameter int unsigned VPN_W   = tlb_pkg::DEF_VPN_W,
    parameter int unsigned OFF_W   = tlb_pkg::DEF_OFF_W,
    parameter int unsigned PFN_W   = tlb_pkg::DEF_PFN_W,
    parameter int unsigned AGE_W   = tlb_pkg::DEF_AGE_W,
    localparam int unsigned VA_W   = VPN_W + OFF_W,
    localparam int unsigned PA_W   = PFN_W + OFF_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lk_valid,
    input  logic             lk_write,
    input  logic [VA_W-1:0]  lk_vaddr,
    output logic             lk_hit,
    output logic [PA_W-1:0]  lk_paddr,
    output logic             lk_dirty,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PFN_W-1:0] fill_pfn,
    input  logic             fill_dirty,
    input  logic             inv_all
);
    import tlb_pkg::*;

    localparam int unsigned IDX_W = idx_width(ENTRIES);

    logic [ENTRIES-1:0] valid_q;
    logic [ENTRIES-1:0] dirty_q;
    logic [VPN_W-1:0]   tag_q [ENTRIES];
    logic [PFN_W-1:0]   pfn_q [ENTRIES];
    logic [AGE_W-1:0]   age_q [ENTRIES];
    logic [AGE_W-1:0]   age_nxt [ENTRIES];

    logic [ENTRIES-1:0] hit_vec;
    logic               cam_hit;
    logic [IDX_W-1:0]   hit_idx;
    logic [PFN_W-1:0]   hit_pfn;
    logic               hit_dirty;
    logic [IDX_W-1:0]   victim_idx;
    logic [IDX_W-1:0]   age_sel;
    tlb_op_e            op;

    tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_cam (
        .valid_vec (valid_q),
        .tag_arr   (tag_q),
        .pfn_arr   (pfn_q),
        .dirty_vec (dirty_q),
        .key       (lk_vaddr[VA_W-1:OFF_W]),
        .hit_vec   (hit_vec),
        .any_hit   (cam_hit),
        .hit_idx   (hit_idx),
        .hit_pfn   (hit_pfn),
        .hit_dirty (hit_dirty)
    );

    tlb_victim #(.ENTRIES(ENTRIES), .AGE_W(AGE_W)) u_victim (
        .valid_vec  (valid_q),
        .age_arr    (age_q),
        .victim_idx (victim_idx)
    );

    tlb_age #(.ENTRIES(ENTRIES), .AGE_W(AGE_W)) u_age (
        .valid_vec (valid_q),
        .age_arr   (age_q),
        .sel_idx   (age_sel),
        .age_nxt   (age_nxt)
    );

    assign lk_hit   = lk_valid && cam_hit;
    assign lk_paddr = lk_hit ? {hit_pfn, lk_vaddr[OFF_W-1:0]} : '0;
    assign lk_dirty = lk_hit && hit_dirty;

    always_comb begin
        if (inv_all)
            op = OP_FLUSH;
        else if (fill_en)
            op = OP_FILL;
        else if (lk_hit)
            op = OP_TOUCH;
        else
            op = OP_IDLE;
    end

    assign age_sel = (op == OP_FILL) ? victim_idx : hit_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            dirty_q <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                tag_q[i] <= '0;
                pfn_q[i] <= '0;
                age_q[i] <= '0;
            end
        end else begin
            unique case (op)
                OP_FLUSH: valid_q <= '0;
                OP_FILL: begin
                    valid_q[victim_idx] <= 1'b1;
                    dirty_q[victim_idx] <= fill_dirty;
                    tag_q[victim_idx]   <= fill_vpn;
                    pfn_q[victim_idx]   <= fill_pfn;
                    age_q               <= age_nxt;
                end
                OP_TOUCH: begin
                    age_q <= age_nxt;
                    if (lk_write)
                        dirty_q[hit_idx] <= 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/tlb_chk.sv
module tlb_chk #(
    parameter int unsigned ENTRIES = tlb_pkg::DEF_ENTRIES,
    parameter int unsigned VPN_W   = tlb_pkg::DEF_VPN_W,
    parameter int unsigned OFF_W   = tlb_pkg::DEF_OFF_W,
    parameter int unsigned PFN_W   = tlb_pkg::DEF_PFN_W
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     lk_valid,
    input logic                     lk_write,
    input logic [VPN_W+OFF_W-1:0]   lk_vaddr,
    input logic                     lk_hit,
    input logic [PFN_W+OFF_W-1:0]   lk_paddr,
    input logic                     lk_dirty,
    input logic                     fill_en,
    input logic                     inv_all,
    input logic [ENTRIES-1:0]       hit_vec,
    input logic [ENTRIES-1:0]       valid_q
);
    logic past_ok;
    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    // R1
    reset_empty_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (valid_q == '0 && !lk_hit));

    // R2
    single_match_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

    // R2
    hit_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> lk_valid);

    // R3
    offset_pass_chk: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> (lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]));

    // R4
    miss_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> (lk_paddr == '0 && !lk_dirty));

    // R5
    dirty_sticks_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(lk_valid && lk_write && lk_hit && !fill_en && !inv_all)
         && lk_hit && (lk_vaddr[VPN_W+OFF_W-1:OFF_W] == $past(lk_vaddr[VPN_W+OFF_W-1:OFF_W])))
        |-> lk_dirty);

    // R10
    flush_all_chk: assert property (@(posedge clk) disable iff (rst)
        inv_all |=> (valid_q == '0));
endmodule

bind tlb_fa tlb_chk #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .OFF_W(OFF_W), .PFN_W(PFN_W)
) u_chk (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_write(lk_write),
    .lk_vaddr(lk_vaddr), .lk_hit(lk_hit), .lk_paddr(lk_paddr),
    .lk_dirty(lk_dirty), .fill_en(fill_en), .inv_all(inv_all),
    .hit_vec(hit_vec), .valid_q(valid_q)
);

// File: tb/sim_tlb_fa.sv
`timescale 1ns/1ps
module sim_tlb_fa;
    localparam int N     = 8;
    localparam int VPN_W = 30;
    localparam int OFF_W = 13;
    localparam int PFN_W = 21;
    localparam int AMAX  = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lk_valid = 0, lk_write = 0, fill_en = 0, fill_dirty = 0, inv_all = 0;
    logic [VPN_W+OFF_W-1:0] lk_vaddr = '0;
    logic [VPN_W-1:0] fill_vpn = '0;
    logic [PFN_W-1:0] fill_pfn = '0;
    logic lk_hit, lk_dirty;
    logic [PFN_W+OFF_W-1:0] lk_paddr;

    always #2 clk = ~clk;

    tlb_fa #(.ENTRIES(N), .VPN_W(VPN_W), .OFF_W(OFF_W), .PFN_W(PFN_W), .AGE_W(2)) u0 (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_write(lk_write),
        .lk_vaddr(lk_vaddr), .lk_hit(lk_hit), .lk_paddr(lk_paddr),
        .lk_dirty(lk_dirty), .fill_en(fill_en), .fill_vpn(fill_vpn),
        .fill_pfn(fill_pfn), .fill_dirty(fill_dirty), .inv_all(inv_all)
    );

    // Reference table
    bit             m_valid [N];
    bit             m_dirty [N];
    bit [VPN_W-1:0] m_tag [N];
    bit [PFN_W-1:0] m_pfn [N];
    int             m_age [N];
    bit [VPN_W-1:0] pool [16];

    int checks = 0, fails = 0;
    bit done = 0;

    function automatic int find(input bit [VPN_W-1:0] vpn);
        for (int i = 0; i < N; i++)
            if (m_valid[i] && m_tag[i] == vpn) return i;
        return -1;
    endfunction

    function automatic int pick_victim();
        for (int i = 0; i < N; i++) if (!m_valid[i]) return i;
        for (int i = 0; i < N; i++) if (m_age[i] == AMAX) return i;
        return 0;
    endfunction

    task automatic age_touch(input int sel);
        for (int i = 0; i < N; i++) begin
            if (i == sel) m_age[i] = 0;
            else if (m_valid[i] && m_age[i] < AMAX) m_age[i] = m_age[i] + 1;
        end
    endtask

    task automatic check(input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One clock: drive at negedge, compare combinational outputs, then update model
    task automatic step(input string req, input bit lv, input bit wr,
                        input bit [VPN_W-1:0] vpn, input bit [OFF_W-1:0] off,
                        input bit fe, input bit [VPN_W-1:0] fv,
                        input bit [PFN_W-1:0] fp, input bit fd, input bit inv);
        int idx, vic;
        bit eh;
        longint epa;
        @(negedge clk);
        lk_valid = lv; lk_write = wr; lk_vaddr = {vpn, off};
        fill_en = fe; fill_vpn = fv; fill_pfn = fp; fill_dirty = fd; inv_all = inv;
        #1;
        idx = find(vpn);
        eh  = lv && (idx >= 0);
        epa = eh ? longint'({m_pfn[idx], off}) : 0;
        check(req, "hit", longint'(lk_hit), longint'(eh));
        check(req, "paddr", longint'(lk_paddr), epa);
        check(req, "dirty", longint'(lk_dirty), eh ? longint'(m_dirty[idx]) : 0);
        @(posedge clk);
        if (inv) begin
            for (int i = 0; i < N; i++) m_valid[i] = 0;
        end else if (fe) begin
            vic = pick_victim();
            age_touch(vic);
            m_valid[vic] = 1; m_tag[vic] = fv; m_pfn[vic] = fp; m_dirty[vic] = fd;
        end else if (eh) begin
            age_touch(idx);
            if (wr) m_dirty[idx] = 1;
        end
    endtask

    task automatic look(input string req, input bit [VPN_W-1:0] vpn, input bit wr);
        step(req, 1, wr, vpn, OFF_W'($urandom), 0, '0, '0, 0, 0);
    endtask

    task automatic fill(input string req, input bit [VPN_W-1:0] vpn,
                        input bit [PFN_W-1:0] pfn, input bit d);
        step(req, 0, 0, '0, '0, 1, vpn, pfn, d, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int k = 0; k < 16; k++) pool[k] = {26'($urandom), 4'(k)};
        for (int i = 0; i < N; i++) begin
            m_valid[i] = 0; m_dirty[i] = 0; m_tag[i] = 0; m_pfn[i] = 0; m_age[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R1: empty after reset
        look("R1", pool[0], 0);
        look("R1", 30'd0, 0);

        // R7 R9: fills go to free slots in order, each readable
        for (int k = 0; k < N; k++) fill("R7", pool[k], 21'(k * 1111 + 5), 1'(k == 2));
        for (int k = 0; k < N; k++) begin
            step("R2", 1, 0, pool[k], 13'h1abc, 0, '0, '0, 0, 0);
            check("R3", "frame", longint'(lk_paddr[OFF_W+PFN_W-1:OFF_W]), longint'(k * 1111 + 5));
        end
        // R2: request low gives no hit even for a stored page
        step("R2", 0, 0, pool[3], 13'h5, 0, '0, '0, 0, 0);
        // R4: dirty taken from fill flag
        look("R4", pool[2], 0);
        // R5: write hit then reads dirty
        look("R5", pool[5], 1);
        look("R5", pool[5], 0);
        check("R5", "dirty_after_write", longint'(lk_dirty), 1);
        // R6 R8: touch slot 0 then fill; oldest lowest slot evicted
        look("R6", pool[0], 0);
        fill("R8", pool[8], 21'h1f00f, 0);
        look("R8", pool[0], 0);
        look("R8", pool[8], 0);
        look("R8", pool[1], 0);
        // R11: fill and write hit together: dirty untouched
        step("R11", 1, 1, pool[4], 13'h7, 1, pool[9], 21'h0abcd, 0, 0);
        look("R11", pool[4], 0);
        look("R11", pool[9], 0);
        // R10: invalidate beats a fill in the same cycle
        step("R10", 1, 0, pool[4], 13'h0, 1, pool[10], 21'h3, 0, 1);
        for (int k = 0; k < 12; k++) look("R10", pool[k], 0);
        // R7: refill after flush lands in slot order again
        fill("R7", pool[11], 21'h77, 0);
        look("R7", pool[11], 0);

        // Random mix
        for (int t = 0; t < 4000; t++) begin
            int r;
            bit [VPN_W-1:0] v;
            r = int'($urandom_range(0, 99));
            v = pool[$urandom_range(0, 15)];
            if (r < 2)
                step("R10", $urandom_range(0, 1) == 1, 0, v, OFF_W'($urandom), 0, '0, '0, 0, 1);
            else if (r < 30 && find(v) < 0)
                step("R9", $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
                     pool[$urandom_range(0, 15)], OFF_W'($urandom), 1, v,
                     PFN_W'($urandom), 1'($urandom_range(0, 1)), 0);
            else
                step("R6", $urandom_range(0, 9) != 0, $urandom_range(0, 3) == 0,
                     v, OFF_W'($urandom), 0, '0, '0, 0, 0);
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule